// File: doc/BRIEF.md
# Two-slot byte DMA channel

This block moves single bytes between a memory request port and a byte-wide device stream, in a direction picked by software. It holds two descriptor slots, A and B. Software writes a slot's base address, length and last flag, then arms the slot by setting its valid flag in the control register. The engine works through one slot, clears that slot's flag when it is done, and then moves to the other slot if that slot is armed. This lets software refill one slot while the other is draining.

Each finished slot raises its own one-cycle completion interrupt. When the finished slot carried the last flag, the engine also sends a one-cycle terminal-count strobe to the device. Before a transfer starts, the engine checks the descriptor and rejects it if the buffer would cross a 4096-byte page, or if the transfer is an input whose base address is not 64-byte aligned. An error reported by memory aborts the slot. Both kinds of fault raise a shared error interrupt. A diagnostic word reports the slot in use, whether the engine is active, and how many bytes remain.

Top module: `byte_dma_pingpong`

## Requirements
- R1: With control bit 0 at 0, the bytes read from memory at base, base+1, ... base+len-1 are presented on the device output stream in that order.
- R2: With control bit 0 at 1, the bytes accepted from the device input stream are written to memory at ascending addresses, starting at base.
- R3: When a slot finishes, the engine pulses its completion interrupt (irq_a for A, irq_b for B) for exactly one cycle. It also clears that slot's valid flag: control bit 4 for A, bit 3 for B.
- R4: Descriptor bit 63 (last) makes tc_pulse strobe for one cycle, in the same cycle as the completion interrupt. With the bit clear, there is no strobe. The descriptor holds the base in bits 31:0 and the length in bits 43:32.
- R5: A descriptor whose page offset (base[11:0]) plus length is more than 4096 is rejected. The engine raises irq_err, issues no memory request, clears the valid flag and gives no completion interrupt. A buffer that ends exactly on the last byte of a page is accepted.
- R6: For an input transfer, a base with base[5:0] not zero is rejected in the same way as R5. For an output transfer, any byte alignment is accepted.
- R7: A length of zero finishes at once, with no memory request. It still gives the completion interrupt, and the strobe if the last flag is set.
- R8: After reset the engine serves slot A first. When a slot finishes, it moves to the other slot if that slot is valid. Otherwise it idles until a flag is set.
- R9: With control bit 1 (enable) at 0, the channel freezes: no request, no handshake, and the position and remaining count stay unchanged. It resumes correctly when the bit returns to 1.
- R10: While control bit 2 is 1, both valid flags, the remaining count and the slot pointer are held at zero, and a write that tries to set a valid flag has no effect.
- R11: The diagnostic word gives the slot in use in bit 0 (0 = A), the active flag in bit 1 (enabled and not idle), and the remaining byte count in bits 13:2.
- R12: An acknowledge with mem_err aborts the slot. The engine raises irq_err, clears the valid flag and gives no completion interrupt. The remaining count keeps the number of bytes not yet moved.
- R13: If a software write sets a valid flag in the same cycle that the hardware clears it on completion, the set wins, and the slot runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 5 | Control write data: bit0 dir, bit1 enable, bit2 channel reset, bit3 set B valid, bit4 set A valid (writing 0 to bit 3 or 4 has no effect) |
| ctl_q | output | 5 | Control readback; bits 4 and 3 show the A and B valid flags |
| desc_we | input | 1 | Descriptor write strobe |
| desc_sel | input | 1 | Descriptor slot written: 0 = A, 1 = B |
| desc_wdata | input | 64 | Descriptor: base 31:0, length 43:32, last 63 |
| diag_q | output | 14 | Diagnostic: remaining 13:2, active 1, slot 0 |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request accepted / data valid |
| mem_err | input | 1 | Error reported together with mem_ack |
| dout_valid | output | 1 | Output byte valid |
| dout_data | output | 8 | Output byte |
| dout_ready | input | 1 | Device takes the output byte |
| din_valid | input | 1 | Input byte valid |
| din_data | input | 8 | Input byte |
| din_ready | output | 1 | Engine takes the input byte |
| tc_pulse | output | 1 | Terminal-count strobe to the device |
| irq_a | output | 1 | Slot A completion pulse |
| irq_b | output | 1 | Slot B completion pulse |
| irq_err | output | 1 | Rejected descriptor or memory error pulse |

## Verification
Two things can fall in the same clock edge: the hardware clearing a slot's valid flag as that slot finishes, and a software control write setting the same flag. The bench waits for the cycle in which irq_a is visible and issues the arming write in that cycle, so both reach the flag together. The outcome is judged at the ports. A second completion interrupt must follow, and the scoreboard must see the same four bytes twice, in order. After the second run the flag must read back clear.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
    // Engine sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE, ST_LOAD, ST_RD, ST_PUSH, ST_PULL, ST_WR, ST_DONE, ST_ERR
    } eng_state_e;
    // Slot index values.
    localparam logic SLOT_A = 1'b0;
    localparam logic SLOT_B = 1'b1;
endpackage

// File: rtl/pdma_regs.sv
// Control register, valid flags and descriptor storage for both slots.
// Assumes: valid bits are set by writing 1 and cleared by hardware;
// a set in the same cycle as a hardware clear wins; channel reset overrides both.
module pdma_regs #(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 12,
    parameter int DESC_W   = 64,
    parameter int LEN_LSB  = 32,
    parameter int LAST_BIT = 63
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_we,
    input  logic [4:0]             ctl_wdata,
    input  logic                   desc_we,
    input  logic                   desc_sel,
    input  logic [DESC_W-1:0]      desc_wdata,
    input  logic [1:0]             hw_clr_i,
    output logic                   dir_o,
    output logic                   en_o,
    output logic                   crst_o,
    output logic [1:0]             valid_o,
    output logic [1:0][ADDR_W-1:0] base_o,
    output logic [1:0][LEN_W-1:0]  len_o,
    output logic [1:0]             last_o
);
    logic [1:0] set_req;
    logic       unused_desc;

    assign unused_desc = ^desc_wdata;
    // Slot A is armed by bit 4, slot B by bit 3.
    assign set_req = ctl_we ? {ctl_wdata[3], ctl_wdata[4]} : 2'b00;

    // Mode bits: direction, enable, channel reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_o  <= 1'b0;
            en_o   <= 1'b0;
            crst_o <= 1'b0;
        end else if (ctl_we) begin
            dir_o  <= ctl_wdata[0];
            en_o   <= ctl_wdata[1];
            crst_o <= ctl_wdata[2];
        end
    end

    for (genvar s = 0; s < 2; s++) begin : g_slot
        // Valid flag: reset clears, software set beats hardware clear.
        always_ff @(posedge clk) begin
            if (!rst_n || crst_o)  valid_o[s] <= 1'b0;
            else if (set_req[s])   valid_o[s] <= 1'b1;
            else if (hw_clr_i[s])  valid_o[s] <= 1'b0;
        end

        // Descriptor fields captured on a write to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_o[s] <= '0;
                len_o[s]  <= '0;
                last_o[s] <= 1'b0;
            end else if (desc_we && (desc_sel == 1'(s))) begin
                base_o[s] <= desc_wdata[ADDR_W-1:0];
                len_o[s]  <= desc_wdata[LEN_LSB +: LEN_W];
                last_o[s] <= desc_wdata[LAST_BIT];
            end
        end

        // R13
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_req[s] && !crst_o) |=> valid_o[s]);
    end

    // R10
    crst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crst_o |=> (valid_o == 2'b00));
endmodule

// File: rtl/pdma_check.sv
// Descriptor screening: page crossing for any direction, 64-byte
// alignment for input. Purely combinational; assumes len fits LEN_W.
module pdma_check #(
    parameter int LEN_W   = 12,
    parameter int PAGE_W  = 12,
    parameter int ALIGN_W = 6
) (
    input  logic [PAGE_W-1:0] base_low_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              dir_i,
    output logic              bad_o
);
    localparam int SUM_W = ((LEN_W > PAGE_W) ? LEN_W : PAGE_W) + 1;
    localparam logic [SUM_W-1:0] PAGE_BYTES = SUM_W'(1) << PAGE_W;

    logic [SUM_W-1:0] end_off;
    logic             crosses;
    logic             misaligned;

    // Flag a buffer that spills over its page, or a misaligned input base.
    always_comb begin
        end_off    = SUM_W'(base_low_i) + SUM_W'(len_i);
        crosses    = end_off > PAGE_BYTES;
        misaligned = dir_i && (|base_low_i[ALIGN_W-1:0]);
        bad_o      = crosses || misaligned;
    end
endmodule

// File: rtl/pdma_engine.sv
// Byte mover: picks a slot, loads and screens its descriptor, then
// moves one byte per memory handshake plus one stream handshake.
// Assumes mem_ack is only given while mem_req is high.
module pdma_engine
    import pdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              clr_i,
    input  logic              dir_i,
    input  logic [1:0]        valid_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              last_i,
    input  logic              bad_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ack_i,
    input  logic              mem_err_i,
    output logic              dout_valid_o,
    output logic [DATA_W-1:0] dout_data_o,
    input  logic              dout_ready_i,
    input  logic              din_valid_i,
    input  logic [DATA_W-1:0] din_data_i,
    output logic              din_ready_o,
    output logic [1:0]        hw_clr_o,
    output logic              tc_o,
    output logic              irq_a_o,
    output logic              irq_b_o,
    output logic              irq_err_o,
    output logic              ptr_o,
    output logic              active_o,
    output logic [LEN_W-1:0]  rem_o
);
    eng_state_e        st_q;
    logic              ptr_q, last_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q, len_q;
    logic [DATA_W-1:0] hold_q;
    logic              fin, done;

    // Sequencer: slot choice, descriptor load, byte transfer, wrap-up.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            st_q   <= ST_IDLE;
            ptr_q  <= SLOT_A;
            last_q <= 1'b0;
            addr_q <= '0;
            rem_q  <= '0;
            len_q  <= '0;
            hold_q <= '0;
        end else if (en_i) begin
            case (st_q)
                ST_IDLE: begin
                    if (valid_i[ptr_q])       st_q  <= ST_LOAD;
                    else if (valid_i[~ptr_q]) ptr_q <= ~ptr_q;
                end
                ST_LOAD: begin
                    last_q <= last_i;
                    addr_q <= base_i;
                    len_q  <= len_i;
                    rem_q  <= bad_i ? '0 : len_i;
                    if (bad_i)              st_q <= ST_ERR;
                    else if (len_i == '0)   st_q <= ST_DONE;
                    else                    st_q <= dir_i ? ST_PULL : ST_RD;
                end
                ST_RD: if (mem_ack_i) begin
                    hold_q <= mem_rdata_i;
                    st_q   <= mem_err_i ? ST_ERR : ST_PUSH;
                end
                ST_PUSH: if (dout_ready_i) begin
                    addr_q <= addr_q + ADDR_W'(1);
                    rem_q  <= rem_q - LEN_W'(1);
                    st_q   <= (rem_q == LEN_W'(1)) ? ST_DONE : ST_RD;
                end
                ST_PULL: if (din_valid_i) begin
                    hold_q <= din_data_i;
                    st_q   <= ST_WR;
                end
                ST_WR: if (mem_ack_i) begin
                    if (mem_err_i) st_q <= ST_ERR;
                    else begin
                        addr_q <= addr_q + ADDR_W'(1);
                        rem_q  <= rem_q - LEN_W'(1);
                        st_q   <= (rem_q == LEN_W'(1)) ? ST_DONE : ST_PULL;
                    end
                end
                default: begin
                    st_q <= ST_IDLE;
                    if (valid_i[~ptr_q]) ptr_q <= ~ptr_q;
                end
            endcase
        end
    end

    // Port decode of the current state, gated by enable.
    always_comb begin
        done         = en_i && (st_q == ST_DONE);
        irq_err_o    = en_i && (st_q == ST_ERR);
        fin          = done || irq_err_o;
        hw_clr_o     = fin ? (2'b01 << ptr_q) : 2'b00;
        irq_a_o      = done && (ptr_q == SLOT_A);
        irq_b_o      = done && (ptr_q == SLOT_B);
        tc_o         = done && last_q;
        mem_req_o    = en_i && ((st_q == ST_RD) || (st_q == ST_WR));
        mem_we_o     = (st_q == ST_WR);
        mem_addr_o   = addr_q;
        mem_wdata_o  = hold_q;
        dout_valid_o = en_i && (st_q == ST_PUSH);
        dout_data_o  = hold_q;
        din_ready_o  = en_i && (st_q == ST_PULL);
        ptr_o        = ptr_q;
        active_o     = en_i && (st_q != ST_IDLE);
        rem_o        = rem_q;
    end

    // R3
    irq_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_a_o || irq_b_o) |=> !(irq_a_o || irq_b_o));
    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> ($stable(rem_q) && $stable(addr_q) && $stable(st_q)));
    // R11
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && st_q != ST_LOAD) |-> (rem_q <= len_q));
    // R12
    mem_err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i && mem_err_i && !clr_i) |=> (st_q == ST_ERR));
    // R1
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid_o && dout_ready_i && !clr_i) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));
endmodule

// File: rtl/byte_dma_pingpong.sv
// Top: two-slot byte DMA channel. Joins the register file, the
// descriptor screen for the selected slot and the byte engine.
// Assumes descriptors are rewritten only for a slot not being loaded.
module byte_dma_pingpong #(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 12,
    parameter int DATA_W   = 8,
    parameter int DESC_W   = 64,
    parameter int LEN_LSB  = 32,
    parameter int LAST_BIT = 63,
    parameter int PAGE_W   = 12,
    parameter int ALIGN_W  = 6,
    localparam int DIAG_W  = LEN_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [4:0]        ctl_wdata,
    output logic [4:0]        ctl_q,
    input  logic              desc_we,
    input  logic              desc_sel,
    input  logic [DESC_W-1:0] desc_wdata,
    output logic [DIAG_W-1:0] diag_q,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              dout_valid,
    output logic [DATA_W-1:0] dout_data,
    input  logic              dout_ready,
    input  logic              din_valid,
    input  logic [DATA_W-1:0] din_data,
    output logic              din_ready,
    output logic              tc_pulse,
    output logic              irq_a,
    output logic              irq_b,
    output logic              irq_err
);
    logic                   dir, en, crst, ptr, active, bad;
    logic [1:0]             valid, hw_clr, last_s;
    logic [1:0][ADDR_W-1:0] base_s;
    logic [1:0][LEN_W-1:0]  len_s;
    logic [LEN_W-1:0]       rem;

    pdma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DESC_W(DESC_W),
                .LEN_LSB(LEN_LSB), .LAST_BIT(LAST_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .desc_we(desc_we), .desc_sel(desc_sel), .desc_wdata(desc_wdata),
        .hw_clr_i(hw_clr), .dir_o(dir), .en_o(en), .crst_o(crst),
        .valid_o(valid), .base_o(base_s), .len_o(len_s), .last_o(last_s));

    pdma_check #(.LEN_W(LEN_W), .PAGE_W(PAGE_W), .ALIGN_W(ALIGN_W)) u_check (
        .base_low_i(base_s[ptr][PAGE_W-1:0]), .len_i(len_s[ptr]),
        .dir_i(dir), .bad_o(bad));

    pdma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .en_i(en), .clr_i(crst), .dir_i(dir),
        .valid_i(valid), .base_i(base_s[ptr]), .len_i(len_s[ptr]),
        .last_i(last_s[ptr]), .bad_i(bad),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
        .mem_err_i(mem_err), .dout_valid_o(dout_valid), .dout_data_o(dout_data),
        .dout_ready_i(dout_ready), .din_valid_i(din_valid), .din_data_i(din_data),
        .din_ready_o(din_ready), .hw_clr_o(hw_clr), .tc_o(tc_pulse),
        .irq_a_o(irq_a), .irq_b_o(irq_b), .irq_err_o(irq_err),
        .ptr_o(ptr), .active_o(active), .rem_o(rem));

    // Readback words.
    assign ctl_q  = {valid[0], valid[1], crst, en, dir};
    assign diag_q = {rem, active, ptr};
endmodule

// File: tb/sim_byte_dma_pingpong.sv
module sim_byte_dma_pingpong;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [4:0]  ctl_wdata = '0;
    logic [4:0]  ctl_q;
    logic        desc_we = 1'b0;
    logic        desc_sel = 1'b0;
    logic [63:0] desc_wdata = '0;
    logic [13:0] diag_q;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic        dout_valid;
    logic [7:0]  dout_data;
    logic        dout_ready = 1'b1;
    logic        din_valid = 1'b0;
    logic [7:0]  din_data = '0;
    logic        din_ready, tc_pulse, irq_a, irq_b, irq_err;

    always #10 clk = ~clk;

    byte_dma_pingpong u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
        .desc_we(desc_we), .desc_sel(desc_sel), .desc_wdata(desc_wdata), .diag_q(diag_q),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .dout_valid(dout_valid), .dout_data(dout_data), .dout_ready(dout_ready),
        .din_valid(din_valid), .din_data(din_data), .din_ready(din_ready),
        .tc_pulse(tc_pulse), .irq_a(irq_a), .irq_b(irq_b), .irq_err(irq_err));

    int n_cmp = 0, n_bad = 0;
    int cnt_a = 0, cnt_b = 0, cnt_err = 0, cnt_tc = 0, cnt_req = 0;
    logic [7:0]  exp_out[$];
    logic [39:0] exp_wr[$];
    logic [7:0]  src_q[$];
    logic [7:0]  e8;
    logic [39:0] e40;
    logic        err_arm = 1'b0;
    logic [31:0] err_addr = '0;
    logic        src_pend = 1'b0;
    logic        bp = 1'b0;
    bit          done_flag = 1'b0;

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Monitor and device/memory models, all acting at the falling edge.
    always @(negedge clk) begin
        if (irq_a)   cnt_a++;
        if (irq_b)   cnt_b++;
        if (irq_err) cnt_err++;
        if (tc_pulse) cnt_tc++;
        dout_ready = bp ? ~dout_ready : 1'b1;
        if (dout_valid && dout_ready) begin
            if (exp_out.size() == 0) chk(0, "R1 unexpected output byte", dout_data, 0);
            else begin
                e8 = exp_out.pop_front();
                chk(dout_data == e8, "R1 output byte order", dout_data, e8);
            end
        end
        if (mem_req && !mem_ack) begin
            mem_ack = 1'b1;
            cnt_req++;
            mem_err = err_arm && (mem_addr == err_addr);
            if (mem_err) err_arm = 1'b0;
            mem_rdata = pat(mem_addr);
            if (mem_we && !mem_err) begin
                if (exp_wr.size() == 0) chk(0, "R2 unexpected write", {mem_addr, mem_wdata}, 0);
                else begin
                    e40 = exp_wr.pop_front();
                    chk({mem_addr, mem_wdata} == e40, "R2 write addr/data", {mem_addr, mem_wdata}, e40);
                end
            end
        end else begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end
        if (src_pend) void'(src_q.pop_front());
        din_valid = (src_q.size() > 0);
        din_data  = din_valid ? src_q[0] : 8'h00;
        src_pend  = din_valid && din_ready;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [4:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_desc(input logic sel, input logic [31:0] base, input logic [11:0] len, input logic last);
        @(negedge clk);
        desc_we = 1'b1; desc_sel = sel;
        desc_wdata = {last, 19'b0, len, base};
        @(negedge clk); desc_we = 1'b0;
    endtask

    task automatic push_out(input logic [31:0] base, input int len);
        for (int i = 0; i < len; i++) exp_out.push_back(pat(base + 32'(i)));
    endtask

    task automatic push_in(input logic [31:0] base, input int len, input logic [7:0] seed);
        for (int i = 0; i < len; i++) begin
            logic [7:0] d;
            d = seed + 8'(i * 7);
            src_q.push_back(d);
            exp_wr.push_back({base + 32'(i), d});
        end
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int a0, b0, e0, t0, r0;
        logic [13:0] d0;
        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        // R10 R11: reset state
        chk(ctl_q == 5'b0, "R10 ctl after reset", ctl_q, 0);
        chk(diag_q == 14'b0, "R11 diag after reset", diag_q, 0);

        // R1 R3 R4 R11: output of slot A with last flag
        wr_desc(1'b0, 32'h100, 12'd16, 1'b1);
        push_out(32'h100, 16);
        wr_ctl(5'b10010);
        cyc(6);
        chk(diag_q[1:0] == 2'b10, "R11 active on slot A", diag_q[1:0], 2'b10);
        chk(diag_q[13:2] > 0 && diag_q[13:2] <= 16, "R11 remaining in range", diag_q[13:2], 16);
        cyc(80);
        chk(cnt_a == 1 && cnt_b == 0, "R3 slot A completion", cnt_a, 1);
        chk(cnt_tc == 1, "R4 tc with last flag", cnt_tc, 1);
        chk(ctl_q[4] == 1'b0, "R3 valid A cleared", ctl_q[4], 0);
        chk(exp_out.size() == 0, "R1 all bytes delivered", exp_out.size(), 0);

        // R8 R4 R6: both slots, order A then B, no last flag, odd base, backpressure
        bp = 1'b1;
        wr_desc(1'b0, 32'h300, 12'd3, 1'b0);
        wr_desc(1'b1, 32'h203, 12'd5, 1'b0);
        push_out(32'h300, 3);
        push_out(32'h203, 5);
        wr_ctl(5'b11010);
        cyc(100);
        bp = 1'b0;
        chk(cnt_a == 2 && cnt_b == 1, "R8 A then B both completed", {cnt_a, cnt_b}, {32'd2, 32'd1});
        chk(cnt_tc == 1, "R4 no tc without last", cnt_tc, 1);
        chk(diag_q[1:0] == 2'b01, "R11 idle pointing at B", diag_q[1:0], 2'b01);
        chk(exp_out.size() == 0, "R8 queue drained", exp_out.size(), 0);

        // R2 R3 R8: input on slot A, aligned base, last flag
        wr_desc(1'b0, 32'h440, 12'd8, 1'b1);
        wr_ctl(5'b00011);
        push_in(32'h440, 8, 8'h3C);
        wr_ctl(5'b10011);
        cyc(60);
        chk(cnt_a == 3 && cnt_tc == 2, "R2 input slot completed", {cnt_a, cnt_tc}, {32'd3, 32'd2});
        chk(exp_wr.size() == 0, "R2 all writes seen", exp_wr.size(), 0);

        // R6: misaligned input base rejected
        r0 = cnt_req; b0 = cnt_b; e0 = cnt_err;
        wr_desc(1'b1, 32'h481, 12'd4, 1'b0);
        wr_ctl(5'b01011);
        cyc(20);
        chk(cnt_err == e0 + 1 && cnt_b == b0, "R6 misaligned input rejected", cnt_err - e0, 1);
        chk(cnt_req == r0, "R6 no memory request", cnt_req - r0, 0);
        chk(ctl_q[3] == 1'b0, "R6 valid B cleared", ctl_q[3], 0);

        // R5: page crossing rejected, exact page end accepted
        wr_ctl(5'b00010);
        e0 = cnt_err; a0 = cnt_a; b0 = cnt_b;
        wr_desc(1'b0, 32'hFF8, 12'd9, 1'b0);
        wr_desc(1'b1, 32'h1FF8, 12'd8, 1'b0);
        push_out(32'h1FF8, 8);
        wr_ctl(5'b11010);
        cyc(80);
        chk(cnt_err == e0 + 1 && cnt_a == a0, "R5 crossing rejected", cnt_err - e0, 1);
        chk(cnt_b == b0 + 1 && exp_out.size() == 0, "R5 page-end accepted", cnt_b - b0, 1);

        // R7: zero length with last flag
        r0 = cnt_req; a0 = cnt_a; t0 = cnt_tc;
        wr_desc(1'b0, 32'h900, 12'd0, 1'b1);
        wr_ctl(5'b10010);
        cyc(15);
        chk(cnt_a == a0 + 1 && cnt_tc == t0 + 1, "R7 zero length completes with tc", {cnt_a - a0, cnt_tc - t0}, {32'd1, 32'd1});
        chk(cnt_req == r0, "R7 no memory request", cnt_req - r0, 0);

        // R9: freeze and resume
        b0 = cnt_b;
        wr_desc(1'b1, 32'h500, 12'd10, 1'b0);
        push_out(32'h500, 10);
        wr_ctl(5'b01010);
        cyc(8);
        wr_ctl(5'b00000);
        r0 = cnt_req; d0 = diag_q;
        cyc(20);
        chk(cnt_req == r0, "R9 no requests while frozen", cnt_req - r0, 0);
        chk(diag_q[13:2] == d0[13:2] && diag_q[1] == 1'b0, "R9 position held", diag_q, d0);
        wr_ctl(5'b00010);
        cyc(60);
        chk(cnt_b == b0 + 1 && exp_out.size() == 0, "R9 resumed and finished", cnt_b - b0, 1);

        // R12: memory error aborts after three bytes
        a0 = cnt_a; e0 = cnt_err;
        wr_desc(1'b0, 32'h600, 12'd6, 1'b0);
        push_out(32'h600, 3);
        err_addr = 32'h603; err_arm = 1'b1;
        wr_ctl(5'b10010);
        cyc(40);
        chk(cnt_err == e0 + 1 && cnt_a == a0, "R12 error, no completion", cnt_err - e0, 1);
        chk(diag_q[13:2] == 12'd3, "R12 remaining kept", diag_q[13:2], 3);
        chk(ctl_q[4] == 1'b0 && exp_out.size() == 0, "R12 valid cleared, prefix only", ctl_q[4], 0);

        // R10: channel reset mid transfer
        wr_desc(1'b0, 32'h700, 12'd20, 1'b0);
        push_out(32'h700, 20);
        wr_ctl(5'b10010);
        cyc(8);
        wr_ctl(5'b00110);
        cyc(2);
        chk(ctl_q == 5'b00110, "R10 flags cleared", ctl_q, 5'b00110);
        chk(diag_q == 14'b0, "R10 pointer and count cleared", diag_q, 0);
        wr_ctl(5'b01110);
        cyc(1);
        chk(ctl_q[3] == 1'b0, "R10 set ignored during reset", ctl_q[3], 0);
        wr_ctl(5'b00010);
        exp_out.delete();
        r0 = cnt_req;
        cyc(10);
        chk(cnt_req == r0 && diag_q[1] == 1'b0, "R10 idle after reset", cnt_req - r0, 0);

        // R13: re-arm A in the very cycle it completes
        a0 = cnt_a;
        wr_desc(1'b0, 32'h800, 12'd4, 1'b0);
        push_out(32'h800, 4);
        push_out(32'h800, 4);
        wr_ctl(5'b10010);
        do @(negedge clk); while (!irq_a);
        ctl_we = 1'b1; ctl_wdata = 5'b10010;
        @(negedge clk); ctl_we = 1'b0;
        cyc(40);
        chk(cnt_a == a0 + 2, "R13 set wins, slot reran", cnt_a - a0, 2);
        chk(exp_out.size() == 0 && ctl_q[4] == 1'b0, "R13 both passes delivered", exp_out.size(), 0);

        summary();
        $finish;
    end
endmodule